// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block holds a single load-linked reservation for one processor and resolves each conditional store against it. A load-linked request and a conditional store share one address path: the effective address is the base register value plus the sign-extended 16-bit immediate, and the operation size (4-byte word or 8-byte doubleword) sets the alignment rule. A legal load-linked sets the reservation flag and records the aligned address. A snooped write that lands in the reserved 8-byte granule, or an exception return, drops the flag.

A legal conditional store always issues a write request and holds it until the memory side answers. The answer takes one of four forms. A stall makes the store end with a stall pulse and nothing else changed, so the pipeline can replay it. A failure or bus error ends the store with no register writeback. A success completes the store: the destination register receives the reservation flag as a 0/1 value, and the flag is cleared. Completed stores are counted in saturating counters, one for all stores and one for those that returned 0.

Top module: `llsc_monitor`

## Requirements
- R1: The effective address is `base_val + sign_extend(imm16)`. For an accepted conditional store, `mem_req` rises one cycle after the issue edge and carries that address on `mem_addr`. `mem_req` and `mem_addr` hold until the edge at which `mem_resp_valid` is sampled.
- R2: A word request (`op_dword`=0) whose address has bit 1 or bit 0 set pulses `exc_addr` for one cycle after the issue edge. It makes no write request and sets no reservation.
- R3: A doubleword request whose address has any of bits 2..0 set pulses `exc_addr` and makes no write request.
- R4: A doubleword request while `wide_en`=0 pulses `exc_rsvd` (and not `exc_addr`), whatever its alignment. It makes no write request and sets no reservation.
- R5: A legal `ll_set` (sampled only when `op_valid`=0 and no store is outstanding) sets the reservation flag. A later store completing with response 2'b00 (success) then pulses `rd_we` with `rd_val`=1.
- R6: The flag is cleared by `eret`. It is also cleared by a snoop whose `snoop_addr` falls in the same 8-byte granule (equal bits 63..3) as the recorded address. A store completing after either event returns `rd_val`=0. A snoop in another granule leaves the flag set.
- R7: Response 2'b01 (stall) pulses `stall_o` one cycle after its edge, with no `rd_we` and no counter change. The flag is unchanged, so a replay can still return 1.
- R8: Responses 2'b10 (failure) and 2'b11 (bus error) end the store with no `rd_we`, no `stall_o` and no counter change. The flag is left as it was.
- R9: A completing store clears the flag, so a second store with no new `ll_set` returns 0.
- R10: Each completion increments `cnt_total`, and each completion that returns 0 also increments `cnt_fail`. Both counters saturate at all ones and reset to 0.
- R11: `mem_dword` follows the request size. `mem_wdata` carries `src_data` for a doubleword, and for a word it carries bits 31..0 of `src_data` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Conditional store issue |
| op_dword | input | 1 | Size of store or load-linked: 1 doubleword, 0 word |
| wide_en | input | 1 | 64-bit operation enabled |
| base_val | input | XLEN | Base register value |
| imm16 | input | 16 | Signed offset |
| src_data | input | XLEN | Store data |
| ll_set | input | 1 | Load-linked pulse, uses the same address inputs |
| snoop_valid | input | 1 | Snooped write seen |
| snoop_addr | input | XLEN | Address of the snooped write |
| eret | input | 1 | Exception return, drops the reservation |
| mem_req | output | 1 | Write request outstanding |
| mem_addr | output | XLEN | Write address |
| mem_wdata | output | XLEN | Write data |
| mem_dword | output | 1 | Write size |
| mem_resp_valid | input | 1 | Memory answer present |
| mem_resp | input | 2 | 00 success, 01 stall, 10 failure, 11 bus error |
| rd_we | output | 1 | Destination register write pulse |
| rd_val | output | XLEN | Store result, 0 or 1 |
| exc_addr | output | 1 | Address-error pulse |
| exc_rsvd | output | 1 | Reserved-instruction pulse |
| stall_o | output | 1 | Stall pulse, store must be replayed |
| cnt_total | output | CNT_W | Completed conditional stores, saturating |
| cnt_fail | output | CNT_W | Completions that returned 0, saturating |

## Verification
The bench builds the block with XLEN at 64 and CNT_W at 3. Both counters therefore reach their ceiling of 7 within a few hundred random operations, so the saturation and the ordering between the two counters are exercised and not just assumed. The 8-byte snoop granule together with a narrow random address window makes snoops hit and miss the reservation often. Negative immediates reach the sign-extension path.

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor #(
  parameter int XLEN    = 64,
  parameter int CNT_W   = 16,
  parameter int GRAN_LG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_dword,
  input  logic             wide_en,
  input  logic [XLEN-1:0]  base_val,
  input  logic [15:0]      imm16,
  input  logic [XLEN-1:0]  src_data,
  input  logic             ll_set,
  input  logic             snoop_valid,
  input  logic [XLEN-1:0]  snoop_addr,
  input  logic             eret,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             mem_dword,
  input  logic             mem_resp_valid,
  input  logic [1:0]       mem_resp,
  output logic             rd_we,
  output logic [XLEN-1:0]  rd_val,
  output logic             exc_addr,
  output logic             exc_rsvd,
  output logic             stall_o,
  output logic [CNT_W-1:0] cnt_total,
  output logic [CNT_W-1:0] cnt_fail
);
  localparam logic [1:0] RSP_OK    = 2'd0;
  localparam logic [1:0] RSP_STALL = 2'd1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [XLEN-1:0] LO_WORD = {{(XLEN-32){1'b0}}, {32{1'b1}}};

  logic            busy;
  logic            link_flag;
  logic [XLEN-1:0] link_addr;

  wire [XLEN-1:0] ea       = base_val + {{(XLEN-16){imm16[15]}}, imm16};
  wire            misalign = op_dword ? (|ea[2:0]) : (|ea[1:0]);
  wire            rsvd     = op_dword && !wide_en;
  wire [XLEN-1:0] align_m  = {{(XLEN-3){1'b1}}, ~op_dword, 2'b00};
  wire            issue    = op_valid && !busy;
  wire            ll_go    = ll_set && !op_valid && !busy;
  wire            ll_ok    = ll_go && !rsvd && !misalign;
  wire            resp     = busy && mem_resp_valid;
  wire            done     = resp && (mem_resp == RSP_OK);
  wire            snoop_hit = snoop_valid &&
                              ((snoop_addr >> GRAN_LG) == (link_addr >> GRAN_LG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_dword <= 1'b0;
      rd_we     <= 1'b0;
      rd_val    <= '0;
      exc_addr  <= 1'b0;
      exc_rsvd  <= 1'b0;
      stall_o   <= 1'b0;
      cnt_total <= '0;
      cnt_fail  <= '0;
    end else begin
      exc_addr <= 1'b0;
      exc_rsvd <= 1'b0;
      rd_we    <= 1'b0;
      stall_o  <= 1'b0;
      if (issue || ll_go) begin
        if (rsvd)          exc_rsvd <= 1'b1;
        else if (misalign) exc_addr <= 1'b1;
        else if (issue) begin
          busy      <= 1'b1;
          mem_req   <= 1'b1;
          mem_addr  <= ea;
          mem_wdata <= op_dword ? src_data : (src_data & LO_WORD);
          mem_dword <= op_dword;
        end
      end
      if (resp) begin
        busy    <= 1'b0;
        mem_req <= 1'b0;
        if (mem_resp == RSP_STALL) stall_o <= 1'b1;
        if (done) begin
          rd_we  <= 1'b1;
          rd_val <= {{(XLEN-1){1'b0}}, link_flag};
          if (cnt_total != CNT_MAX) cnt_total <= cnt_total + 1'b1;
          if (!link_flag && cnt_fail != CNT_MAX) cnt_fail <= cnt_fail + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_flag <= 1'b0;
      link_addr <= '1;
    end else begin
      if (snoop_hit || eret || done) link_flag <= 1'b0;
      else if (ll_ok)                link_flag <= 1'b1;
      if (done && link_flag) link_addr <= '1;
      else if (ll_ok)        link_addr <= ea & align_m;
    end
  end

  a_r2_word_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !op_dword && (|ea[1:0]) |=> exc_addr && !mem_req);
  a_r3_dword_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_dword && wide_en && (|ea[2:0]) |=> exc_addr && !mem_req);
  a_r4_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (issue || ll_go) && rsvd |=> exc_rsvd && !exc_addr && !mem_req);
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_resp_valid |=> mem_req && $stable(mem_addr));
  a_r7_stall_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    resp && mem_resp == RSP_STALL && !snoop_hit && !eret
    |=> link_flag == $past(link_flag) && !rd_we && stall_o);
  a_r8_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    resp && mem_resp[1] |=> !rd_we && !stall_o && $stable(cnt_total));
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !link_flag);
  a_r5_result_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd_val[XLEN-1:1] == '0);
  a_r10_fail_le_total: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fail <= cnt_total);
  a_r10_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_total >= $past(cnt_total) && cnt_fail >= $past(cnt_fail));
endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
  localparam int XLEN = 64;
  localparam int CNT_W = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_dword = 0, wide_en = 1;
  logic [XLEN-1:0] base_val = '0, src_data = '0, snoop_addr = '0;
  logic [15:0] imm16 = '0;
  logic ll_set = 0, snoop_valid = 0, eret = 0;
  logic mem_resp_valid = 0;
  logic [1:0] mem_resp = 0;
  logic mem_req, mem_dword, rd_we, exc_addr, exc_rsvd, stall_o;
  logic [XLEN-1:0] mem_addr, mem_wdata, rd_val;
  logic [CNT_W-1:0] cnt_total, cnt_fail;

  always #10 clk = ~clk;

  llsc_monitor #(.XLEN(XLEN), .CNT_W(CNT_W), .GRAN_LG(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dword(op_dword),
    .wide_en(wide_en), .base_val(base_val), .imm16(imm16), .src_data(src_data),
    .ll_set(ll_set), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .eret(eret),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_dword(mem_dword),
    .mem_resp_valid(mem_resp_valid), .mem_resp(mem_resp), .rd_we(rd_we), .rd_val(rd_val),
    .exc_addr(exc_addr), .exc_rsvd(exc_rsvd), .stall_o(stall_o),
    .cnt_total(cnt_total), .cnt_fail(cnt_fail));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  bit m_flag = 0;
  logic [XLEN-1:0] m_laddr = '1;
  int m_total = 0, m_fails = 0;

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] f_ea(logic [XLEN-1:0] b, logic [15:0] i);
    return b + {{(XLEN-16){i[15]}}, i};
  endfunction
  function automatic logic [XLEN-1:0] f_wdata(logic [XLEN-1:0] d, bit dw);
    return dw ? d : {32'h0, d[31:0]};
  endfunction
  function automatic bit f_mis(logic [XLEN-1:0] a, bit dw);
    return dw ? (a[2:0] != 0) : (a[1:0] != 0);
  endfunction

  // returns 1 if the store reached memory and got a stall
  task automatic sc_op(logic [XLEN-1:0] b, logic [15:0] i, logic [XLEN-1:0] d,
                       bit dw, bit we, logic [1:0] rc, output bit stalled);
    logic [XLEN-1:0] a;
    a = f_ea(b, i);
    stalled = 0;
    @(negedge clk);
    op_valid = 1; base_val = b; imm16 = i; src_data = d; op_dword = dw; wide_en = we;
    @(negedge clk);
    op_valid = 0;
    if (dw && !we) begin
      check("R4 exc_rsvd", exc_rsvd, 1);
      check("R4 no exc_addr", exc_addr, 0);
      check("R4 no req", mem_req, 0);
    end else if (f_mis(a, dw)) begin
      check(dw ? "R3 exc_addr" : "R2 exc_addr", exc_addr, 1);
      check(dw ? "R3 no req" : "R2 no req", mem_req, 0);
    end else begin
      check("R1 req", mem_req, 1);
      check("R1 addr", mem_addr, a);
      check("R11 wdata", mem_wdata, f_wdata(d, dw));
      check("R11 size", mem_dword, dw);
      @(negedge clk);
      check("R1 req held", mem_req, 1);
      mem_resp_valid = 1; mem_resp = rc;
      @(negedge clk);
      mem_resp_valid = 0;
      if (rc == 2'd1) begin
        stalled = 1;
        check("R7 stall", stall_o, 1);
        check("R7 no wb", rd_we, 0);
      end else if (rc[1]) begin
        check("R8 no wb", rd_we, 0);
        check("R8 no stall", stall_o, 0);
      end else begin
        check("R5 rd_we", rd_we, 1);
        check("R5 R6 R9 result", rd_val, {63'b0, m_flag});
        if (m_total < CMAX) m_total++;
        if (!m_flag && m_fails < CMAX) m_fails++;
        if (m_flag) m_laddr = '1;
        m_flag = 0;
      end
      check("R10 total", cnt_total, XLEN'(m_total));
      check("R10 fail", cnt_fail, XLEN'(m_fails));
    end
  endtask

  task automatic ll_op(logic [XLEN-1:0] b, logic [15:0] i, bit dw, bit we);
    logic [XLEN-1:0] a;
    a = f_ea(b, i);
    @(negedge clk);
    ll_set = 1; base_val = b; imm16 = i; op_dword = dw; wide_en = we;
    @(negedge clk);
    ll_set = 0;
    if (dw && !we) check("R4 ll exc_rsvd", exc_rsvd, 1);
    else if (f_mis(a, dw)) check("R2 ll exc_addr", exc_addr, 1);
    else begin
      check("R5 ll no exc", {exc_addr, exc_rsvd}, 0);
      m_flag = 1;
      m_laddr = a & {{61{1'b1}}, ~dw, 2'b00};
    end
  endtask

  task automatic snoop_op(logic [XLEN-1:0] a);
    @(negedge clk);
    snoop_valid = 1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 0;
    if ((a >> 3) == (m_laddr >> 3)) m_flag = 0;
  endtask

  task automatic eret_op();
    @(negedge clk); eret = 1;
    @(negedge clk); eret = 0;
    m_flag = 0;
  endtask

  task automatic sc_ok(logic [XLEN-1:0] b, logic [15:0] i, bit dw);
    bit s;
    sc_op(b, i, 64'hA5A5_5A5A_DEAD_BEEF, dw, 1, 2'd0, s);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 reset total", cnt_total, 0);
    check("R10 reset fail", cnt_fail, 0);
    check("R1 reset req", mem_req, 0);
    check("R5 reset rd_we", rd_we, 0);

    sc_ok(64'h1000, 16'hFFFC, 0);                 // R1 negative offset, no link -> 0
    ll_op(64'h2000, 16'h0010, 0, 1);
    sc_ok(64'h2000, 16'h0010, 0);                 // R5 -> 1
    sc_ok(64'h2000, 16'h0010, 0);                 // R9 -> 0
    sc_op(64'h2002, 16'h0000, 64'h1, 0, 1, 2'd0, s);   // R2
    ll_op(64'h2001, 16'h0000, 0, 1);              // R2 ll misaligned, no link
    sc_ok(64'h2000, 16'h0000, 0);                 // R2 -> 0
    sc_op(64'h2004, 16'h0000, 64'h1, 1, 1, 2'd0, s);   // R3
    ll_op(64'h3000, 16'h0000, 1, 1);
    sc_op(64'h3000, 16'h0008, 64'h1122_3344_5566_7788, 1, 1, 2'd0, s); // R11 dword -> 1
    ll_op(64'h3000, 16'h0000, 1, 0);              // R4 ll reserved
    sc_op(64'h3000, 16'h0000, 64'h1, 1, 0, 2'd0, s);   // R4
    sc_ok(64'h3000, 16'h0000, 1);                 // R4 no link -> 0
    ll_op(64'h4000, 16'h0000, 0, 1);
    sc_op(64'h4000, 16'h0000, 64'h7, 0, 1, 2'd1, s);   // R7 stall
    sc_ok(64'h4000, 16'h0000, 0);                 // R7 replay -> 1
    ll_op(64'h4000, 16'h0000, 0, 1);
    sc_op(64'h4000, 16'h0000, 64'h7, 0, 1, 2'd3, s);   // R8 bus error
    sc_op(64'h4000, 16'h0000, 64'h7, 0, 1, 2'd2, s);   // R8 failure
    sc_ok(64'h4000, 16'h0000, 0);                 // R8 flag kept -> 1
    ll_op(64'h5000, 16'h0000, 0, 1);
    snoop_op(64'h5008);                           // R6 other granule
    sc_ok(64'h5000, 16'h0000, 0);                 // -> 1
    ll_op(64'h5000, 16'h0004, 0, 1);
    snoop_op(64'h5001);                           // R6 hit
    sc_ok(64'h5000, 16'h0004, 0);                 // -> 0
    ll_op(64'h5000, 16'h0000, 0, 1);
    eret_op();                                    // R6 eret
    sc_ok(64'h5000, 16'h0000, 0);                 // -> 0

    for (int k = 0; k < 400; k++) begin
      logic [XLEN-1:0] b;
      logic [15:0] i;
      int sel;
      b = 64'h6000 + XLEN'($urandom % 16);
      i = 16'hFFF8 + 16'($urandom % 24);
      sel = $urandom % 10;
      if (sel < 3) ll_op(b, i, ($urandom % 3) == 0, ($urandom % 4) != 0);
      else if (sel < 8) begin
        sc_op(b, i, {$urandom, $urandom}, ($urandom % 3) == 0, ($urandom % 4) != 0,
              2'($urandom % 4), s);
      end else if (sel < 9) snoop_op(64'h6000 + XLEN'($urandom % 32) - 64'h10);
      else eret_op();
    end
    check("R10 total saturated", cnt_total, XLEN'(CMAX));
    check("R10 fail saturated", cnt_fail, XLEN'(CMAX));

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule